// File: doc/BRIEF.md
# Extended-Float to Integer Store Unit

This unit turns the 80-bit extended-precision value held at the top of a floating-point register stack into a signed integer of 16, 32 or 64 bits, ready for a memory write. It applies the rounding mode chosen by the caller. It detects invalid and inexact results and an empty source register. It then decides whether the store may go ahead and, when a popping form is requested, moves the stack pointer.

Each request is presented for one cycle with `reqValid`. The conversion itself is combinational. The result, the store-enable, the exception flags, the condition bit and the stack update are all captured in registers and appear one cycle later. Address generation and the memory access belong to the surrounding pipeline.

Source layout:
- bit 79 is the sign.
- bits 78:64 hold the exponent, biased by 16383.
- bits 63:0 hold the significand, with its integer bit stored explicitly at bit 63.

Top module: `xfloat_int_store`

## Requirements
- R1: `dstSize` selects the destination width: 00 for 16 bits, 01 for 32 bits and 10 for 64 bits. `resultOut` carries the integer sign-extended to 64 bits. A request with size 10 and `popReq` low, or with size 11, is rejected: no response follows and the stack pointer is unchanged.
- R2: A fractional source is rounded according to `roundMode`:
  - 00: to nearest, ties to even.
  - 01: toward minus infinity.
  - 10: toward plus infinity.
  - 11: toward zero.
- R3: Positive zero, negative zero and any value that rounds to zero give 0. A value of magnitude 1 or more gives the correctly signed integer. This includes the most negative value of each width.
- R4: `flagInvalid` is raised in any of these cases:
  - the exponent is all ones (infinity or NaN);
  - the exponent is nonzero while significand bit 63 is clear;
  - the rounded result does not fit the destination width;
  - the top register is empty.
- R5: On an invalid result with `invalidMask` set, `storeEn` is 1 and the value is the most negative number of the width (0x8000, 0x80000000 or 0x8000000000000000, sign-extended). With `invalidMask` clear, `storeEn` is 0 and `resultOut` is 0.
- R6: `flagInexact` is 1 when a valid conversion discards nonzero fraction bits. `condC1` is 1 only when such a conversion increased the magnitude; it is 0 in every other case.
- R7: When `topEmpty` is set, `flagUnderflow` is raised together with `flagInvalid`, and `condC1` is 0.
- R8: An accepted request with `popReq` set and no unmasked invalid result does three things:
  - asserts `popDone`;
  - reports the freed register index `stackPtr` on `emptyIdx`;
  - sets `newTopPtr` to `stackPtr`+1 modulo 8.

  Otherwise `newTopPtr` becomes `stackPtr` on an accepted request and holds when no request is accepted.
- R9: All outputs are registered. They reflect an accepted request in the cycle after it. `respValid`, `storeEn`, `popDone` and all flags are 0 in any cycle that follows no accepted request, and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| srcVal | input | 80 | Extended-precision source value |
| topEmpty | input | 1 | Tag: top register is empty |
| roundMode | input | 2 | Rounding mode |
| invalidMask | input | 1 | Invalid-operation mask |
| dstSize | input | 2 | Destination width select |
| popReq | input | 1 | Popping form requested |
| stackPtr | input | 3 | Current stack top index |
| resultOut | output | 64 | Sign-extended integer |
| storeEn | output | 1 | Store may be performed |
| flagInvalid | output | 1 | Invalid-operand flag |
| flagInexact | output | 1 | Inexact flag |
| flagUnderflow | output | 1 | Stack underflow flag |
| condC1 | output | 1 | Round-up indicator |
| respValid | output | 1 | Response for an accepted request |
| popDone | output | 1 | Stack was popped |
| emptyIdx | output | 3 | Register index to tag empty |
| newTopPtr | output | 3 | Updated stack top index |

## Verification
Every result of this unit is due exactly one rising edge after the request is driven. That includes the integer, the store-enable, the flags, `condC1`, `respValid` and the stack update. The bench changes inputs on the falling edge and compares all outputs on the following falling edge, once the single capturing edge has passed. The next vector is driven only after that comparison. Rejected requests and idle cycles are checked on the same schedule: one edge later, `respValid` must be low and `newTopPtr` must still hold the last accepted value.

// File: rtl/xfloat_store_pkg.sv
package xfloat_store_pkg;
  localparam int SRC_W  = 80;
  localparam int MAN_W  = 64;
  localparam int EXP_W  = 15;
  localparam int RES_W  = 64;
  localparam int PTR_W  = 3;
  localparam int EXP_BIAS = 16383;

  typedef enum logic [1:0] {
    RND_NEAR  = 2'b00,
    RND_DOWN  = 2'b01,
    RND_UP    = 2'b10,
    RND_TRUNC = 2'b11
  } roundSel_t;

  typedef enum logic [1:0] {
    SZ_16 = 2'b00,
    SZ_32 = 2'b01,
    SZ_64 = 2'b10,
    SZ_NA = 2'b11
  } dstSel_t;

  typedef struct packed {
    logic accept;
  } ctlStrobes_t;
endpackage

// File: rtl/xfloat_store_dpath.sv
module xfloat_store_dpath
  import xfloat_store_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [SRC_W-1:0]  srcVal,
  input  logic              topEmpty,
  input  logic [1:0]        roundMode,
  input  logic              invalidMask,
  input  logic [1:0]        dstSize,
  output logic              blockStore,
  output logic [RES_W-1:0]  resultOut,
  output logic              storeEn,
  output logic              flagInvalid,
  output logic              flagInexact,
  output logic              flagUnderflow,
  output logic              condC1
);
  localparam int SH_W  = $clog2(2*MAN_W);
  localparam int UNB_W = EXP_W + 2;

  logic                 sgn;
  logic [EXP_W-1:0]     expo;
  logic [MAN_W-1:0]     mant;
  logic signed [UNB_W-1:0] unb;
  logic [SH_W-1:0]      sh;
  logic [2*MAN_W-1:0]   shifted;
  logic [MAN_W-1:0]     intPart;
  logic                 rBit, sticky, inexact, incr;
  logic                 isSpecial, unsupported, tooBig, fits, invalid;
  logic [MAN_W:0]       mag, posLimit;
  logic [RES_W-1:0]     sVal, sExt, indef;

  assign sgn  = srcVal[SRC_W-1];
  assign expo = srcVal[SRC_W-2 -: EXP_W];
  assign mant = srcVal[MAN_W-1:0];
  assign unb  = $signed({2'b00, expo}) - UNB_W'(EXP_BIAS);

  assign isSpecial   = &expo;
  assign unsupported = (expo != '0) && !mant[MAN_W-1];
  assign tooBig      = (expo != '0) && (unb >= UNB_W'(MAN_W));

  always_comb begin
    if (expo == '0)                    sh = '1;
    else if (unb >= UNB_W'(MAN_W-1))   sh = '0;
    else if (unb < -UNB_W'(MAN_W))     sh = '1;
    else                               sh = SH_W'(UNB_W'(MAN_W-1) - unb);
  end

  assign shifted = {mant, {MAN_W{1'b0}}} >> sh;

  always_comb begin
    if (expo == '0) begin
      intPart = '0;
      rBit    = 1'b0;
      sticky  = |mant;
    end else begin
      intPart = shifted[2*MAN_W-1:MAN_W];
      rBit    = shifted[MAN_W-1];
      sticky  = |shifted[MAN_W-2:0];
    end
  end

  assign inexact = rBit | sticky;

  always_comb begin
    unique case (roundSel_t'(roundMode))
      RND_NEAR:  incr = rBit & (sticky | intPart[0]);
      RND_DOWN:  incr = sgn & inexact;
      RND_UP:    incr = ~sgn & inexact;
      default:   incr = 1'b0;
    endcase
  end

  assign mag = {1'b0, intPart} + (MAN_W+1)'(incr);

  always_comb begin
    unique case (dstSel_t'(dstSize))
      SZ_16:   posLimit = (MAN_W+1)'(16'h7FFF);
      SZ_32:   posLimit = (MAN_W+1)'(32'h7FFF_FFFF);
      default: posLimit = (MAN_W+1)'(64'h7FFF_FFFF_FFFF_FFFF);
    endcase
  end

  assign fits    = !tooBig && (sgn ? (mag <= posLimit + 1'b1) : (mag <= posLimit));
  assign invalid = topEmpty | isSpecial | unsupported | !fits;
  assign blockStore = invalid & ~invalidMask;

  assign sVal = sgn ? (~mag[RES_W-1:0] + 1'b1) : mag[RES_W-1:0];

  always_comb begin
    unique case (dstSel_t'(dstSize))
      SZ_16: begin
        sExt  = {{(RES_W-16){sVal[15]}}, sVal[15:0]};
        indef = {{(RES_W-15){1'b1}}, 15'h0};
      end
      SZ_32: begin
        sExt  = {{(RES_W-32){sVal[31]}}, sVal[31:0]};
        indef = {{(RES_W-31){1'b1}}, 31'h0};
      end
      default: begin
        sExt  = sVal;
        indef = {1'b1, {(RES_W-1){1'b0}}};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobes.accept) begin
      resultOut     <= '0;
      storeEn       <= 1'b0;
      flagInvalid   <= 1'b0;
      flagInexact   <= 1'b0;
      flagUnderflow <= 1'b0;
      condC1        <= 1'b0;
    end else begin
      resultOut     <= invalid ? (invalidMask ? indef : '0) : sExt;
      storeEn       <= !blockStore;
      flagInvalid   <= invalid;
      flagInexact   <= !invalid && inexact;
      flagUnderflow <= topEmpty;
      condC1        <= !invalid && inexact && incr;
    end
  end

  // R6
  c1_needs_inexact_chk: assert property (@(posedge clk) disable iff (!rstN)
    condC1 |-> flagInexact);
  // R7
  underflow_is_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagUnderflow |-> (flagInvalid && !condC1));
  // R4
  invalid_not_inexact_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagInvalid |-> !flagInexact);
  // R5
  blocked_store_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !storeEn |-> (resultOut == '0));
endmodule

// File: rtl/xfloat_store_ctrl.sv
module xfloat_store_ctrl
  import xfloat_store_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       dstSize,
  input  logic             popReq,
  input  logic [PTR_W-1:0] stackPtr,
  input  logic             blockStore,
  output ctlStrobes_t      strobes,
  output logic             respValid,
  output logic             popDone,
  output logic [PTR_W-1:0] emptyIdx,
  output logic [PTR_W-1:0] newTopPtr
);
  logic sizeOk, doPop;

  always_comb begin
    unique case (dstSel_t'(dstSize))
      SZ_16, SZ_32: sizeOk = 1'b1;
      SZ_64:        sizeOk = popReq;
      default:      sizeOk = 1'b0;
    endcase
  end

  assign strobes.accept = reqValid & sizeOk;
  assign doPop = strobes.accept & popReq & ~blockStore;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      popDone   <= 1'b0;
      emptyIdx  <= '0;
      newTopPtr <= '0;
    end else begin
      respValid <= strobes.accept;
      popDone   <= doPop;
      if (doPop) emptyIdx <= stackPtr;
      if (strobes.accept) newTopPtr <= doPop ? stackPtr + 1'b1 : stackPtr;
    end
  end

  // R9
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accept |=> respValid);
  // R8
  pop_moves_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    popDone |-> (newTopPtr == PTR_W'(emptyIdx + 1'b1)));
  // R1
  idle_holds_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.accept |=> ($stable(newTopPtr) && !respValid));
endmodule

// File: rtl/xfloat_int_store.sv
module xfloat_int_store
  import xfloat_store_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [SRC_W-1:0]  srcVal,
  input  logic              topEmpty,
  input  logic [1:0]        roundMode,
  input  logic              invalidMask,
  input  logic [1:0]        dstSize,
  input  logic              popReq,
  input  logic [PTR_W-1:0]  stackPtr,
  output logic [RES_W-1:0]  resultOut,
  output logic              storeEn,
  output logic              flagInvalid,
  output logic              flagInexact,
  output logic              flagUnderflow,
  output logic              condC1,
  output logic              respValid,
  output logic              popDone,
  output logic [PTR_W-1:0]  emptyIdx,
  output logic [PTR_W-1:0]  newTopPtr
);
  ctlStrobes_t strobes;
  logic        blockStore;

  xfloat_store_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .dstSize(dstSize),
    .popReq(popReq), .stackPtr(stackPtr), .blockStore(blockStore),
    .strobes(strobes), .respValid(respValid), .popDone(popDone),
    .emptyIdx(emptyIdx), .newTopPtr(newTopPtr)
  );

  xfloat_store_dpath uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcVal(srcVal),
    .topEmpty(topEmpty), .roundMode(roundMode), .invalidMask(invalidMask),
    .dstSize(dstSize), .blockStore(blockStore), .resultOut(resultOut),
    .storeEn(storeEn), .flagInvalid(flagInvalid), .flagInexact(flagInexact),
    .flagUnderflow(flagUnderflow), .condC1(condC1)
  );

  // R5
  store_has_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeEn |-> respValid);
endmodule

// File: tb/tb_xfloat_int_store.sv
module tb_xfloat_int_store;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [79:0] srcVal = '0;
  logic        topEmpty = 1'b0;
  logic [1:0]  roundMode = '0;
  logic        invalidMask = 1'b0;
  logic [1:0]  dstSize = '0;
  logic        popReq = 1'b0;
  logic [2:0]  stackPtr = '0;
  logic [63:0] resultOut;
  logic        storeEn, flagInvalid, flagInexact, flagUnderflow, condC1;
  logic        respValid, popDone;
  logic [2:0]  emptyIdx, newTopPtr;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xfloat_int_store dut (.*);

  typedef struct packed {
    logic [79:0] src;
    logic [1:0]  sz;
    logic [1:0]  rc;
    logic        msk;
    logic        pop;
    logic        emp;
    logic [2:0]  ptr;
    logic        st;
    logic [63:0] res;
    logic        inv;
    logic        inx;
    logic        unf;
    logic        c1;
    logic        pd;
    logic [2:0]  nptr;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{80'h3FFF_8000000000000000, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
    '{80'h4000_A000000000000000, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3},
    '{80'h4000_A000000000000000, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3},
    '{80'hC000_A000000000000000, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'hFFFFFFFFFFFFFFFD, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3},
    '{80'hC000_A000000000000000, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'hFFFFFFFFFFFFFFFE, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3},
    '{80'h4000_E000000000000000, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3},
    '{80'h3FFE_C000000000000000, 2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3},
    '{80'hBFFD_8000000000000000, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3},
    '{80'hBFFD_8000000000000000, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3},
    '{80'h8000_0000000000000000, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
    '{80'h400D_FFFE000000000000, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'h7FFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
    '{80'hC00E_8000000000000000, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b1, 64'hFFFFFFFFFFFF8000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
    '{80'h400E_8000000000000000, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'hFFFFFFFFFFFF8000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
    '{80'h400E_8000000000000000, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'h8000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
    '{80'h400D_FFFF000000000000, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'hFFFFFFFFFFFF8000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
    '{80'h7FFF_8000000000000000, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
    '{80'h7FFF_C000000000000000, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'hFFFFFFFF80000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
    '{80'h4000_4000000000000000, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'hFFFFFFFFFFFF8000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
    '{80'h0000_0000000000000001, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3},
    '{80'h0000_0000000000000001, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 64'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3},
    '{80'hC03E_8000000000000000, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 3'd3, 1'b1, 64'h8000000000000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4},
    '{80'h403E_8000000000000000, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 3'd3, 1'b1, 64'h8000000000000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4},
    '{80'h403D_FFFFFFFFFFFFFFFF, 2'd2, 2'd3, 1'b1, 1'b1, 1'b0, 3'd3, 1'b1, 64'h7FFFFFFFFFFFFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd4},
    '{80'h403D_FFFFFFFFFFFFFFFF, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 3'd3, 1'b1, 64'h8000000000000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4},
    '{80'h3FFF_8000000000000000, 2'd1, 2'd0, 1'b1, 1'b1, 1'b1, 3'd7, 1'b1, 64'hFFFFFFFF80000000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd0},
    '{80'h3FFF_8000000000000000, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 3'd2, 1'b0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2},
    '{80'hFFFF_8000000000000000, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 3'd5, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5},
    '{80'h4005_C800000000000000, 2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 3'd7, 1'b1, 64'd100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0}
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] expv);
    nChecks++;
    if (act !== expv) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    reqValid = 1'b1; srcVal = v.src; dstSize = v.sz; roundMode = v.rc;
    invalidMask = v.msk; popReq = v.pop; topEmpty = v.emp; stackPtr = v.ptr;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "reset respValid", 64'(respValid), 64'd0);
    chk("R9", "reset storeEn", 64'(storeEn), 64'd0);
    chk("R9", "reset flags", 64'({flagInvalid, flagInexact, flagUnderflow, condC1}), 64'd0);
    chk("R8", "reset newTopPtr", 64'(newTopPtr), 64'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      chk("R9", $sformatf("v%0d respValid", i), 64'(respValid), 64'd1);
      chk("R2", $sformatf("v%0d result", i), resultOut, VECS[i].res);
      chk("R5", $sformatf("v%0d storeEn", i), 64'(storeEn), 64'(VECS[i].st));
      chk("R4", $sformatf("v%0d invalid", i), 64'(flagInvalid), 64'(VECS[i].inv));
      chk("R6", $sformatf("v%0d inexact/C1", i), 64'({flagInexact, condC1}), 64'({VECS[i].inx, VECS[i].c1}));
      chk("R7", $sformatf("v%0d underflow", i), 64'(flagUnderflow), 64'(VECS[i].unf));
      chk("R8", $sformatf("v%0d pop", i), 64'({popDone, newTopPtr}), 64'({VECS[i].pd, VECS[i].nptr}));
      if (VECS[i].pd)
        chk("R8", $sformatf("v%0d emptyIdx", i), 64'(emptyIdx), 64'(VECS[i].ptr));
    end

    // R9: idle cycle after a request clears strobes (last vector left newTopPtr = 0)
    @(negedge clk);
    chk("R9", "idle respValid/storeEn", 64'({respValid, storeEn, popDone}), 64'd0);

    // R1: 64-bit without pop is rejected, pointer holds
    @(negedge clk);
    reqValid = 1'b1; srcVal = 80'h3FFF_8000000000000000; dstSize = 2'd2;
    popReq = 1'b0; stackPtr = 3'd6; invalidMask = 1'b1; topEmpty = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R1", "64-bit no-pop respValid", 64'(respValid), 64'd0);
    chk("R1", "64-bit no-pop newTopPtr", 64'(newTopPtr), 64'd0);

    // R1: size code 11 rejected
    @(negedge clk);
    reqValid = 1'b1; dstSize = 2'd3; popReq = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R1", "size 11 respValid", 64'({respValid, popDone}), 64'd0);
    chk("R1", "size 11 newTopPtr", 64'(newTopPtr), 64'd0);

    // R3: positive zero with 64-bit pop
    @(negedge clk);
    reqValid = 1'b1; srcVal = '0; dstSize = 2'd2; popReq = 1'b1; stackPtr = 3'd1;
    roundMode = 2'd2;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R3", "+0 result", resultOut, 64'd0);
    chk("R3", "+0 exact", 64'({flagInexact, flagInvalid, storeEn}), 64'b001);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule